// File: doc/BRIEF.md
# Program-Order Matching Receive Buffer

This block sits at the receiving end of a one-way data channel whose items may be delivered in an order that differs from the order in which the receiver wants them. Each item carries an 8-bit sequence tag drawn from program order. Incoming items first land in a FIFO queue. Each cycle the queue head moves into a free slot of a small associative store. The receiver does not pop items in arrival order. Instead it asks for the tag it expects next, and the block searches every occupied slot at once for that tag.

The receiver's expected tag comes from an internal counter. The counter advances only when a request has actually been served, and it wraps from 255 back to 0. A hit returns the data one cycle later and frees the slot. A miss leaves the request pending until the item arrives. A second, independent counter numbers every accepted item, so a sender can use it to stamp tags. A sticky flag reports when two occupied slots would hold the same tag.

Top module: `idmatch_buf`

## Requirements
- R1: After reset, prod_ready is 1, cons_valid is 0, err_dup is 0, cons_exp_id is 0 and prod_seq_id is 0.
- R2: prod_seq_id increases by one for each cycle in which prod_valid and prod_ready are both high, and wraps from 255 to 0.
- R3: With cons_req held high and an item whose tag equals cons_exp_id, cons_valid rises with that item's data after the third rising edge counted from the edge that accepted the item (queue, store, search).
- R4: Items delivered in any tag order are returned in ascending tag order, each with the data it was sent with.
- R5: While no stored item carries the expected tag, a held request produces no response and cons_exp_id does not change.
- R6: cons_exp_id advances by one only on a served request, and wraps from 255 to 0.
- R7: cons_valid is a one-cycle pulse for each served request, and it never rises while cons_req is low.
- R8: The store holds CAM_N items and the queue holds Q_DEPTH items. Draining into the store stops while all slots are occupied, and prod_ready is low exactly when the queue is full. No accepted item is lost.
- R9: err_dup rises the cycle after an item enters the store while another occupied slot, not being freed in that cycle, holds the same tag. It then stays high until reset.
- R10: A served request and a drain from the queue may happen in the same cycle. With a full store and a waiting queue, a held request is served on every consecutive cycle, in tag order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| prod_valid | input | 1 | Incoming item present |
| prod_ready | output | 1 | Queue can accept an item |
| prod_id | input | 8 | Sequence tag of the incoming item |
| prod_data | input | DATA_W | Payload of the incoming item |
| prod_seq_id | output | 8 | Count of accepted items, modulo 256 |
| cons_req | input | 1 | Receiver asks for the item tagged cons_exp_id |
| cons_exp_id | output | 8 | Tag the receiver expects next |
| cons_valid | output | 1 | Response pulse, one cycle per served request |
| cons_data | output | DATA_W | Payload of the served item |
| err_dup | output | 1 | Sticky flag: two slots shared a tag |

## Verification
The two functions that can fall in the same cycle are a search that frees a slot and a drain that fills one. The harshest case is a full store: the slot freed by a hit must be refilled on the next edge, and the next tag must already be present. The bench fills the store and then the queue with consecutive tags while no request is made, and confirms that prod_ready drops after exactly CAM_N plus Q_DEPTH items. It then holds the request high and requires a response with the right payload on every one of the following cycles, with no gap. Any bubble, reordering or lost item therefore shows up as a mismatch on a named cycle.

// File: rtl/idm_pkg.sv
// Shared definitions for the program-order matching receive buffer.
// Assumes tags are 8 bits wide, so all tag arithmetic wraps modulo 256.
package idm_pkg;
    localparam int IDM_ID_W = 8;
    typedef logic [IDM_ID_W-1:0] idm_id_t;
endpackage

// File: rtl/idm_seq_ctr.sv
// Wrapping sequence counter: advances by one when inc is high.
// Assumes the wrap at 2^IDM_ID_W is the intended behaviour.
module idm_seq_ctr
    import idm_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    inc,
    output idm_id_t val
);
    // Count accepted events, clearing on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) val <= '0;
        else if (inc) val <= val + 1'b1;
    end
endmodule

// File: rtl/idm_fifo.sv
// Show-ahead FIFO for tagged items: rd_data shows the head whenever
// empty is low. Assumes DEPTH is a power of two. The caller never writes
// when full and never reads when empty.
module idm_fifo #(
    parameter int WIDTH = 40,
    parameter int DEPTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             full,
    output logic             empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign rd_data = mem[rd_ptr];

    // Store the written item; storage needs no reset.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_data;
    end

    // Move the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en) wr_ptr <= wr_ptr + 1'b1;
            if (rd_en) rd_ptr <= rd_ptr + 1'b1;
            case ({wr_en, rd_en})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R8: the queue is never written beyond its depth.
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !wr_en);
    // R8: the queue is never read while empty.
    a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !rd_en);
endmodule

// File: rtl/idm_cam.sv
// Associative store of N tagged slots. An insert takes the lowest free
// slot. A search compares srch_id against every occupied slot in
// parallel, and a hit frees the lowest matching slot at the edge.
// dup_err latches when an insert meets an occupied slot with the same tag.
// Assumes N is a power of two and ins_en is low while full.
module idm_cam
    import idm_pkg::*;
#(
    parameter int N  = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ins_en,
    input  idm_id_t       ins_id,
    input  logic [DW-1:0] ins_data,
    output logic          full,
    input  logic          srch_en,
    input  idm_id_t       srch_id,
    output logic          hit,
    output logic [DW-1:0] hit_data,
    output logic          dup_err
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0]  vld;
    idm_id_t       tag_q [N];
    logic [DW-1:0] dat_q [N];
    logic [IW-1:0] free_idx, hit_idx;
    logic          take, dup_now;

    // Pick the lowest free slot for the next insert.
    always_comb begin
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!vld[i]) free_idx = IW'(i);
        end
    end

    // Search all occupied slots for the requested tag.
    always_comb begin
        hit_idx = '0;
        hit     = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vld[i] && tag_q[i] == srch_id) begin
                hit_idx = IW'(i);
                hit     = 1'b1;
            end
        end
    end

    assign take     = srch_en && hit;
    assign hit_data = dat_q[hit_idx];
    assign full     = &vld;

    // Detect an insert whose tag is already held by a slot that stays occupied.
    always_comb begin
        dup_now = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (ins_en && vld[i] && tag_q[i] == ins_id &&
                !(take && hit_idx == IW'(i)))
                dup_now = 1'b1;
        end
    end

    // Update slot occupancy and the sticky duplicate flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld     <= '0;
            dup_err <= 1'b0;
        end else begin
            if (ins_en)  vld[free_idx] <= 1'b1;
            if (take)    vld[hit_idx]  <= 1'b0;
            if (dup_now) dup_err       <= 1'b1;
        end
    end

    // Write tag and payload into the slot being filled.
    always_ff @(posedge clk) begin
        if (ins_en) begin
            tag_q[free_idx] <= ins_id;
            dat_q[free_idx] <= ins_data;
        end
    end

    // R8: no insert is attempted while every slot is occupied.
    a_r8_no_insert_full: assert property (@(posedge clk) disable iff (!rst_n)
        ins_en |-> !full);
    // R7: a served search leaves its slot free after the edge.
    a_r7_slot_freed: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !vld[$past(hit_idx)]);
    // R9: the duplicate flag never clears without reset.
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(dup_err) |-> dup_err);
endmodule

// File: rtl/idmatch_buf.sv
// Program-order matching receive buffer. Tagged items pass through a
// FIFO queue into an associative store. The receiver asks for the tag
// held in its own counter; a hit answers one cycle later.
// Assumes Q_DEPTH and CAM_N are powers of two.
module idmatch_buf
    import idm_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int Q_DEPTH = 64,
    parameter int CAM_N   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prod_valid,
    output logic              prod_ready,
    input  logic [7:0]        prod_id,
    input  logic [DATA_W-1:0] prod_data,
    output logic [7:0]        prod_seq_id,
    input  logic              cons_req,
    output logic [7:0]        cons_exp_id,
    output logic              cons_valid,
    output logic [DATA_W-1:0] cons_data,
    output logic              err_dup
);
    localparam int EW = IDM_ID_W + DATA_W;

    logic          q_full, q_empty, drain, accept, take;
    logic [EW-1:0] q_head;
    logic          cam_full, cam_hit;
    logic [DATA_W-1:0] cam_data;

    assign prod_ready = !q_full;
    assign accept     = prod_valid && prod_ready;
    assign drain      = !q_empty && !cam_full;
    assign take       = cons_req && cam_hit;

    idm_fifo #(.WIDTH(EW), .DEPTH(Q_DEPTH)) u_queue (
        .clk(clk), .rst_n(rst_n),
        .wr_en(accept), .wr_data({prod_id, prod_data}),
        .rd_en(drain), .rd_data(q_head),
        .full(q_full), .empty(q_empty)
    );

    idm_cam #(.N(CAM_N), .DW(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .ins_en(drain),
        .ins_id(q_head[EW-1:DATA_W]),
        .ins_data(q_head[DATA_W-1:0]),
        .full(cam_full),
        .srch_en(cons_req), .srch_id(cons_exp_id),
        .hit(cam_hit), .hit_data(cam_data),
        .dup_err(err_dup)
    );

    idm_seq_ctr u_prod_ctr (
        .clk(clk), .rst_n(rst_n), .inc(accept), .val(prod_seq_id)
    );

    idm_seq_ctr u_cons_ctr (
        .clk(clk), .rst_n(rst_n), .inc(take), .val(cons_exp_id)
    );

    // Register the response pulse and hold the last served payload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cons_valid <= 1'b0;
            cons_data  <= '0;
        end else begin
            cons_valid <= take;
            if (take) cons_data <= cam_data;
        end
    end

    // R6: the expected tag moves only together with a response.
    a_r6_id_moves_on_serve: assert property (@(posedge clk) disable iff (!rst_n)
        (cons_exp_id != $past(cons_exp_id)) |-> cons_valid);
    // R7: a request that finds its tag is answered on the next cycle.
    a_r7_resp_follows_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (cons_req && cam_hit) |=> cons_valid);
    // R7: no response follows a cycle without a request.
    a_r7_no_unasked_resp: assert property (@(posedge clk) disable iff (!rst_n)
        !cons_req |=> !cons_valid);
endmodule

// File: tb/tb_idmatch_buf.sv
module tb_idmatch_buf;
    localparam int DW = 32;
    localparam int QD = 64;
    localparam int CN = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          prod_valid = 1'b0;
    logic          prod_ready;
    logic [7:0]    prod_id = '0;
    logic [DW-1:0] prod_data = '0;
    logic [7:0]    prod_seq_id;
    logic          cons_req = 1'b0;
    logic [7:0]    cons_exp_id;
    logic          cons_valid;
    logic [DW-1:0] cons_data;
    logic          err_dup;

    int n_chk = 0;
    int n_bad = 0;
    int n_sent = 0;
    logic [DW-1:0] sent_data [256];

    always #10 clk = ~clk;

    idmatch_buf #(.DATA_W(DW), .Q_DEPTH(QD), .CAM_N(CN)) dut (
        .clk(clk), .rst_n(rst_n),
        .prod_valid(prod_valid), .prod_ready(prod_ready),
        .prod_id(prod_id), .prod_data(prod_data), .prod_seq_id(prod_seq_id),
        .cons_req(cons_req), .cons_exp_id(cons_exp_id),
        .cons_valid(cons_valid), .cons_data(cons_data), .err_dup(err_dup)
    );

    task automatic chk(input logic ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Send one item; called and returning at a falling edge.
    task automatic prod_one(input logic [7:0] id);
        while (!prod_ready) @(negedge clk);
        prod_valid = 1'b1;
        prod_id    = id;
        prod_data  = {16'hBEEF, 8'(n_sent), id};
        sent_data[id] = prod_data;
        n_sent++;
        @(negedge clk);
        prod_valid = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(prod_ready == 1'b1, "R1", "prod_ready", prod_ready, 1);
        chk(cons_valid == 1'b0, "R1", "cons_valid", cons_valid, 0);
        chk(err_dup == 1'b0, "R1", "err_dup", err_dup, 0);
        chk(cons_exp_id == 8'd0, "R1", "cons_exp_id", cons_exp_id, 0);
        chk(prod_seq_id == 8'd0, "R1", "prod_seq_id", prod_seq_id, 0);
    endtask

    // R3 latency and R7 pulse width, tag 0.
    task automatic t_in_order();
        cons_req = 1'b1;
        prod_one(8'd0);
        @(negedge clk);
        chk(cons_valid == 1'b0, "R3", "early response", cons_valid, 0);
        @(negedge clk);
        chk(cons_valid == 1'b1, "R3", "response on third edge", cons_valid, 1);
        chk(cons_data == sent_data[0], "R3", "data", cons_data, sent_data[0]);
        chk(cons_exp_id == 8'd1, "R6", "expected tag after serve", cons_exp_id, 1);
        chk(prod_seq_id == 8'd1, "R2", "accepted count", prod_seq_id, 1);
        cons_req = 1'b0;
        @(negedge clk);
        chk(cons_valid == 1'b0, "R7", "pulse is one cycle", cons_valid, 0);
    endtask

    // R4 reordering, R7 silence without a request.
    task automatic t_out_of_order();
        int got;
        logic seen;
        prod_one(8'd3);
        prod_one(8'd2);
        prod_one(8'd1);
        seen = 1'b0;
        repeat (6) begin
            @(negedge clk);
            if (cons_valid) seen = 1'b1;
        end
        chk(seen == 1'b0, "R7", "response without request", seen, 0);
        chk(cons_exp_id == 8'd1, "R6", "tag held without request", cons_exp_id, 1);
        cons_req = 1'b1;
        got = 0;
        for (int c = 0; c < 20 && got < 3; c++) begin
            @(negedge clk);
            if (cons_valid) begin
                chk(cons_data == sent_data[8'(got + 1)], "R4", "reordered data",
                    cons_data, sent_data[8'(got + 1)]);
                got++;
            end
        end
        cons_req = 1'b0;
        chk(got == 3, "R4", "responses", got, 3);
        chk(cons_exp_id == 8'd4, "R4", "expected tag", cons_exp_id, 4);
    endtask

    // R5 waiting on a miss.
    task automatic t_miss_wait();
        logic seen;
        cons_req = 1'b1;
        seen = 1'b0;
        repeat (10) begin
            @(negedge clk);
            if (cons_valid) seen = 1'b1;
        end
        chk(seen == 1'b0, "R5", "response on miss", seen, 0);
        chk(cons_exp_id == 8'd4, "R5", "tag held on miss", cons_exp_id, 4);
        prod_one(8'd4);
        @(negedge clk);
        @(negedge clk);
        chk(cons_valid == 1'b1, "R5", "late item served", cons_valid, 1);
        chk(cons_data == sent_data[4], "R5", "late item data", cons_data, sent_data[4]);
        cons_req = 1'b0;
        @(negedge clk);
    endtask

    // R8 capacity, R10 serve and drain in the same cycle.
    task automatic t_full_stream();
        int acc;
        acc = 0;
        for (int k = 0; k < CN + QD; k++) begin
            prod_one(8'(5 + k));
            acc++;
        end
        @(negedge clk);
        chk(prod_ready == 1'b0, "R8", "ready low at capacity", prod_ready, 0);
        chk(acc == CN + QD, "R8", "items accepted", acc, CN + QD);
        chk(prod_seq_id == 8'(n_sent), "R2", "accepted count", prod_seq_id, 8'(n_sent));
        cons_req = 1'b1;
        for (int k = 0; k < CN + QD; k++) begin
            @(negedge clk);
            chk(cons_valid == 1'b1, "R10", "back-to-back response", cons_valid, 1);
            chk(cons_data == sent_data[8'(5 + k)], "R10", "stream data",
                cons_data, sent_data[8'(5 + k)]);
        end
        cons_req = 1'b0;
        @(negedge clk);
        chk(cons_exp_id == 8'(5 + CN + QD), "R8", "no item lost",
            cons_exp_id, 8'(5 + CN + QD));
    endtask

    // R6 and R2 wrap from 255 to 0.
    task automatic t_wrap();
        int first, total, got;
        logic [7:0] want;
        first = int'(cons_exp_id);
        total = 256 - first + 2;
        got = 0;
        cons_req = 1'b1;
        fork
            for (int k = 0; k < total; k++) prod_one(8'(first + k));
            for (int c = 0; c < 4 * total && got < total; c++) begin
                @(negedge clk);
                if (cons_valid) begin
                    want = 8'(first + got);
                    if (want == 8'd255 || want == 8'd0 || want == 8'd1)
                        chk(cons_data == sent_data[want], "R6", "data around wrap",
                            cons_data, sent_data[want]);
                    got++;
                end
            end
        join
        cons_req = 1'b0;
        @(negedge clk);
        chk(got == total, "R6", "responses through wrap", got, total);
        chk(cons_exp_id == 8'd2, "R6", "expected tag wrapped", cons_exp_id, 2);
        chk(prod_seq_id == 8'(n_sent), "R2", "count wrapped", prod_seq_id, 8'(n_sent));
    endtask

    // R9 duplicate tag flag.
    task automatic t_dup();
        chk(err_dup == 1'b0, "R9", "flag clear before duplicate", err_dup, 0);
        prod_one(8'd7);
        chk(err_dup == 1'b0, "R9", "flag after first copy queued", err_dup, 0);
        prod_one(8'd7);
        chk(err_dup == 1'b0, "R9", "flag after first copy stored", err_dup, 0);
        @(negedge clk);
        chk(err_dup == 1'b1, "R9", "flag after duplicate stored", err_dup, 1);
        repeat (4) @(negedge clk);
        chk(err_dup == 1'b1, "R9", "flag stays set", err_dup, 1);
    endtask

    initial begin
        t_reset();
        t_in_order();
        t_out_of_order();
        t_miss_wait();
        t_full_stream();
        t_wrap();
        t_dup();
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        summary();
    end
endmodule